// File: doc/BRIEF.md
# I2C Multi-Message Transaction Sequencer

This block walks a list of I2C messages through a byte-level master engine. The engine takes one command at a time and reports each completion with an event. The host therefore sets up a transaction once and does not service an interrupt for every byte. Each message descriptor arrives on a ready/valid stream. A descriptor carries a 7-bit target address, a direction flag, a byte count, a flag that suppresses the START condition, and a flag that marks the final message. Bytes to transmit come from a ready/valid write stream, and received bytes leave on a ready/valid read stream.

A pulse on `go` while the block is idle starts a transaction. The sequencer sends the address of the first message with a START. After that it issues one write or read command per completion event. It chains further messages with a repeated START, or continues straight into their data when the no-start flag is set. A final STOP closes the transaction. NACK on an address or write byte, or arbitration loss on any completion, turns the transaction into an error that still closes with STOP. The completion of that STOP is answered with an interrupt-acknowledge command, and the block then pulses `done` or `err`.

Top module: `i2cseq`

## Requirements
- R1: On `go` while idle, the first descriptor is taken and a START command (code 1) is issued with data {address, direction bit}, where direction bit 1 means read. The no-start flag of the first descriptor is ignored.
- R2: For each byte of a write message, one byte is taken from the write stream and issued as a WRITE command (code 2) carrying that byte. The next byte is taken only after the previous command has completed.
- R3: A completion event with arbitration loss, during an address, write or read, makes the sequencer issue STOP (code 5) on the next cycle, and the transaction ends with `err`.
- R4: A NACK on the completion of an address or write byte makes the sequencer issue STOP, and the transaction ends with `err`.
- R5: Each read completion forwards `ev_rdata` on the read stream in order. Every read except the final byte of a message is commanded with ACK (code 3), and the final byte with NACK (code 4).
- R6: A received byte stays on `rd_data` with `rd_valid` high until it is accepted. No further read command is issued while a byte is pending.
- R7: When a message is exhausted and the finished message is not the final one, the next descriptor is taken. It gets a repeated START with its own address, unless its no-start flag is set, in which case its data phase follows directly.
- R8: After the final message, STOP is issued. The completion of the STOP is answered with IACK (code 6) in the same cycle as the `done` or `err` pulse.
- R9: `done` and `err` are one-cycle pulses and never high together. Both are low after reset, as are `cmd_valid`, `desc_ready`, `wr_ready` and `rd_valid`.
- R10: A message with a byte count of zero is complete right after its address phase.
- R11: A `go` pulse while a transaction is running has no effect. No extra descriptor is taken, no extra command is issued, and no extra `done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Starts a transaction when idle |
| desc_valid | input | 1 | Descriptor available |
| desc_ready | output | 1 | Descriptor taken this cycle |
| desc_addr | input | 7 | Target address |
| desc_rd | input | 1 | 1 = read message |
| desc_len | input | LEN_W | Byte count of the message |
| desc_nostart | input | 1 | Continue without a START |
| desc_last | input | 1 | Final message of the transaction |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte pending |
| rd_ready | input | 1 | Received byte accepted |
| rd_data | output | 8 | Received byte |
| cmd_valid | output | 1 | Command pulse to the byte engine |
| cmd_code | output | 3 | Command code (1..6, see requirements) |
| cmd_data | output | 8 | Address or write byte for the command |
| ev_valid | input | 1 | Engine completion event |
| ev_nack | input | 1 | Target did not acknowledge |
| ev_arblost | input | 1 | Arbitration lost |
| ev_rdata | input | 8 | Byte received by a read |
| done | output | 1 | Transaction completed without error |
| err | output | 1 | Transaction ended through the error path |

## Verification
The bench targets the following corner cases.

- **ACK/NACK choice on reads.** A single-byte read is tested, because it must be commanded with NACK at once; a design that chose by count from the wrong end would ACK it and keep the target driving the bus.
- **Zero-length messages.** These are tested in both directions; a wrong design would issue a stray data command after the address.
- **Fault timing.** NACK is injected on the address and on a middle write byte, and arbitration loss on the address and on a read. A design that checked the fault too late would keep clocking bytes instead of issuing STOP.
- **Chaining and stalls.** Message chaining is tested with both a repeated START and the no-start flag, the read stream is stalled to catch a design that overruns its output byte, and `go` is re-pulsed mid-transaction to catch a second transaction being started.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CMD_NONE    = 3'd0,
    CMD_START   = 3'd1,
    CMD_WRITE   = 3'd2,
    CMD_RD_ACK  = 3'd3,
    CMD_RD_NACK = 3'd4,
    CMD_STOP    = 3'd5,
    CMD_IACK    = 3'd6
  } cmd_e;

  // Logical position within the transaction.
  typedef enum logic [2:0] {
    SQ_DONE, SQ_START, SQ_WRITE, SQ_READ, SQ_ERROR
  } sq_e;

  // Handshake phase of the controller.
  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_SEND, PH_WAIT, PH_FIN
  } ph_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              last;
  } hdr_t;
endpackage

// File: rtl/i2cseq_cmd_reg.sv
module i2cseq_cmd_reg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  output logic [W-1:0] out_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= in_word;
    end
  end
endmodule

// File: rtl/i2cseq_rdbuf.sv
module i2cseq_rdbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (push) begin
      valid <= 1'b1;
      data  <= push_data;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm
  import i2cseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              desc_valid,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic              desc_rd,
  input  logic              desc_nostart,
  input  logic              desc_last,
  input  logic [LEN_W-1:0]  desc_len,
  output logic              desc_ready,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_full,
  output logic              rd_push,
  input  logic              ev_valid,
  input  logic              ev_nack,
  input  logic              ev_arblost,
  output logic              iss_valid,
  output cmd_e              iss_code,
  output logic [BYTE_W-1:0] iss_data,
  output logic              done,
  output logic              err
);
  ph_e             ph, ph_n;
  sq_e             st, st_n;
  hdr_t            hdr, hdr_n;
  logic [LEN_W-1:0] len, len_n, pos, pos_n;
  logic            first, first_n;
  logic            msg_end, end_last;
  logic            fin_ok, fin_bad;

  logic [LEN_W-1:0] pos_inc, len_m1;
  assign pos_inc = pos + 1'b1;
  assign len_m1  = len - 1'b1;

  always_comb begin
    ph_n       = ph;
    st_n       = st;
    hdr_n      = hdr;
    len_n      = len;
    pos_n      = pos;
    first_n    = first;
    msg_end    = 1'b0;
    end_last   = 1'b0;
    iss_valid  = 1'b0;
    iss_code   = CMD_NONE;
    iss_data   = '0;
    rd_push    = 1'b0;
    desc_ready = 1'b0;
    wr_ready   = 1'b0;
    fin_ok     = 1'b0;
    fin_bad    = 1'b0;

    unique case (ph)
      PH_IDLE: begin
        if (go) begin
          ph_n    = PH_LOAD;
          first_n = 1'b1;
        end
      end

      PH_LOAD: begin
        desc_ready = 1'b1;
        if (desc_valid) begin
          hdr_n   = '{addr: desc_addr, rd: desc_rd, last: desc_last};
          len_n   = desc_len;
          pos_n   = '0;
          first_n = 1'b0;
          if (first || !desc_nostart) begin
            iss_valid = 1'b1;
            iss_code  = CMD_START;
            iss_data  = {desc_addr, desc_rd};
            st_n      = SQ_START;
            ph_n      = PH_WAIT;
          end else begin
            st_n = desc_rd ? SQ_READ : SQ_WRITE;
            if (desc_len == '0) begin
              msg_end  = 1'b1;
              end_last = desc_last;
            end else begin
              ph_n = PH_SEND;
            end
          end
        end
      end

      PH_SEND: begin
        if (st == SQ_WRITE) begin
          wr_ready = 1'b1;
          if (wr_valid) begin
            iss_valid = 1'b1;
            iss_code  = CMD_WRITE;
            iss_data  = wr_data;
            pos_n     = pos_inc;
            ph_n      = PH_WAIT;
          end
        end else if (!rd_full) begin
          iss_valid = 1'b1;
          iss_code  = (pos == len_m1) ? CMD_RD_NACK : CMD_RD_ACK;
          ph_n      = PH_WAIT;
        end
      end

      PH_WAIT: begin
        if (ev_valid) begin
          if (ev_arblost) begin
            st_n      = SQ_ERROR;
            iss_valid = 1'b1;
            iss_code  = CMD_STOP;
            ph_n      = PH_FIN;
          end else if (st == SQ_START || st == SQ_WRITE) begin
            if (ev_nack) begin
              st_n      = SQ_ERROR;
              iss_valid = 1'b1;
              iss_code  = CMD_STOP;
              ph_n      = PH_FIN;
            end else begin
              st_n = hdr.rd ? SQ_READ : SQ_WRITE;
              if (pos == len) begin
                msg_end  = 1'b1;
                end_last = hdr.last;
              end else begin
                ph_n = PH_SEND;
              end
            end
          end else begin
            rd_push = 1'b1;
            pos_n   = pos_inc;
            if (pos_inc == len) begin
              msg_end  = 1'b1;
              end_last = hdr.last;
            end else begin
              ph_n = PH_SEND;
            end
          end
        end
      end

      PH_FIN: begin
        if (ev_valid) begin
          iss_valid = 1'b1;
          iss_code  = CMD_IACK;
          fin_ok    = (st == SQ_DONE);
          fin_bad   = (st == SQ_ERROR);
          ph_n      = PH_IDLE;
        end
      end

      default: ph_n = PH_IDLE;
    endcase

    // Shared end-of-message handling: next descriptor or closing STOP.
    if (msg_end) begin
      if (end_last) begin
        st_n      = SQ_DONE;
        iss_valid = 1'b1;
        iss_code  = CMD_STOP;
        iss_data  = '0;
        ph_n      = PH_FIN;
      end else begin
        ph_n = PH_LOAD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      st    <= SQ_DONE;
      hdr   <= '0;
      len   <= '0;
      pos   <= '0;
      first <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      ph    <= ph_n;
      st    <= st_n;
      hdr   <= hdr_n;
      len   <= len_n;
      pos   <= pos_n;
      first <= first_n;
      done  <= fin_ok;
      err   <= fin_bad;
    end
  end
endmodule

// File: rtl/i2cseq.sv
module i2cseq
  import i2cseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [6:0]       desc_addr,
  input  logic             desc_rd,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_nostart,
  input  logic             desc_last,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             cmd_valid,
  output logic [2:0]       cmd_code,
  output logic [7:0]       cmd_data,
  input  logic             ev_valid,
  input  logic             ev_nack,
  input  logic             ev_arblost,
  input  logic [7:0]       ev_rdata,
  output logic             done,
  output logic             err
);
  localparam int WORD_W = CODE_W + BYTE_W;

  logic              iss_valid, rd_push;
  cmd_e              iss_code;
  logic [BYTE_W-1:0] iss_data;
  logic [WORD_W-1:0] cmd_word;

  i2cseq_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .go          (go),
    .desc_valid  (desc_valid),
    .desc_addr   (desc_addr),
    .desc_rd     (desc_rd),
    .desc_nostart(desc_nostart),
    .desc_last   (desc_last),
    .desc_len    (desc_len),
    .desc_ready  (desc_ready),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .wr_ready    (wr_ready),
    .rd_full     (rd_valid),
    .rd_push     (rd_push),
    .ev_valid    (ev_valid),
    .ev_nack     (ev_nack),
    .ev_arblost  (ev_arblost),
    .iss_valid   (iss_valid),
    .iss_code    (iss_code),
    .iss_data    (iss_data),
    .done        (done),
    .err         (err)
  );

  i2cseq_cmd_reg #(.W(WORD_W)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .in_valid (iss_valid),
    .in_word  ({iss_code, iss_data}),
    .out_valid(cmd_valid),
    .out_word (cmd_word)
  );

  assign cmd_code = cmd_word[WORD_W-1:BYTE_W];
  assign cmd_data = cmd_word[BYTE_W-1:0];

  i2cseq_rdbuf #(.W(BYTE_W)) u_rdbuf (
    .clk      (clk),
    .rst      (rst),
    .push     (rd_push),
    .push_data(ev_rdata),
    .pop      (rd_ready),
    .valid    (rd_valid),
    .data     (rd_data)
  );
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       ev_valid,
  input logic       ev_arblost,
  input logic       done,
  input logic       err
);
  AST_FIN_EXCL: assert property (@(posedge clk) disable iff (rst) done |-> !err); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst) err |=> !err); // R9
  AST_FIN_IACK: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> (cmd_valid && cmd_code == 3'd6)); // R8
  AST_ARB_STOP: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_arblost) |=> (cmd_valid && (cmd_code == 3'd5 || cmd_code == 3'd6))); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R6
  AST_RD_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_code == 3'd3 || cmd_code == 3'd4)) |-> !rd_valid); // R6
  AST_WR_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> (cmd_valid && cmd_code == 3'd2)); // R2
endmodule

bind i2cseq i2cseq_chk u_chk (.*);

// File: tb/tb_i2cseq.sv
`timescale 1ns/1ps
module tb_i2cseq;
  localparam int LEN_W = 8;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic go = 1'b0;
  logic desc_valid, desc_ready, desc_rd, desc_nostart, desc_last;
  logic [6:0] desc_addr;
  logic [LEN_W-1:0] desc_len;
  logic wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic cmd_valid;
  logic [2:0] cmd_code;
  logic [7:0] cmd_data;
  logic ev_valid = 1'b0, ev_nack = 1'b0, ev_arblost = 1'b0;
  logic [7:0] ev_rdata = 8'h00;
  logic done, err;

  i2cseq #(.LEN_W(LEN_W)) dut (.*);

  int checks = 0, fails = 0;

  // Descriptor source
  int m_addr[4], m_rd[4], m_len[4], m_ns[4];
  int dn = 0, dptr = 0;
  logic dclr = 1'b0;
  assign desc_valid   = (dptr < dn);
  assign desc_addr    = 7'(m_addr[dptr & 3]);
  assign desc_rd      = m_rd[dptr & 3][0];
  assign desc_len     = LEN_W'(m_len[dptr & 3]);
  assign desc_nostart = m_ns[dptr & 3][0];
  assign desc_last    = (dptr == dn - 1);
  always @(posedge clk) begin
    if (dclr) dptr <= 0;
    else if (desc_valid && desc_ready) dptr <= dptr + 1;
  end

  // Write source: always valid, incrementing bytes
  int wtaken = 0;
  assign wr_valid = 1'b1;
  assign wr_data  = 8'h30 + wtaken[7:0];
  always @(posedge clk) if (wr_valid && wr_ready) wtaken <= wtaken + 1;

  // Byte engine model and read sink
  int fidx = 99, fkind = 0;
  logic lclr = 1'b0;
  int l_code[64], l_data[64];
  int lcnt = 0, rbuf[16], rcnt = 0;
  int pend = 0, pcnt = 0, pidx = 0;
  always @(negedge clk) begin
    if (lclr) begin
      lcnt = 0; rcnt = 0; pend = 0; ev_valid = 1'b0;
    end else begin
      ev_valid = 1'b0; ev_nack = 1'b0; ev_arblost = 1'b0;
      if (pend != 0) begin
        pcnt = pcnt - 1;
        if (pcnt == 0) begin
          ev_valid   = 1'b1;
          ev_nack    = (fkind == 1 && fidx == pidx);
          ev_arblost = (fkind == 2 && fidx == pidx);
          ev_rdata   = 8'hA0 + pidx[7:0];
          pend = 0;
        end
      end
      if (cmd_valid) begin
        l_code[lcnt & 63] = int'(cmd_code);
        l_data[lcnt & 63] = int'(cmd_data);
        if (cmd_code != 3'd6) begin pend = 1; pcnt = LAT; pidx = lcnt; end
        lcnt = lcnt + 1;
      end
      if (rd_valid && rd_ready) begin
        rbuf[rcnt & 15] = int'(rd_data);
        rcnt = rcnt + 1;
      end
    end
  end

  // Expected results
  int e_code[64], e_data[64], e_chk[64], e_rd[16];
  int ecnt, erc, eerr;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build_expected(input int wbase);
    int k = 0, wc = wbase, bad = 0;
    erc = 0;
    for (int m = 0; m < dn && bad == 0; m++) begin
      if (m == 0 || m_ns[m] == 0) begin
        e_code[k] = 1; e_data[k] = m_addr[m] * 2 + m_rd[m]; e_chk[k] = 1;
        if (fkind != 0 && fidx == k) bad = 1;
        k++;
      end
      for (int b = 0; b < m_len[m] && bad == 0; b++) begin
        if (m_rd[m] != 0) begin
          e_code[k] = (b == m_len[m] - 1) ? 4 : 3; e_chk[k] = 0;
          if (fkind == 2 && fidx == k) bad = 1;
          else begin e_rd[erc] = (8'hA0 + k) & 255; erc++; end
        end else begin
          e_code[k] = 2; e_data[k] = (8'h30 + wc) & 255; e_chk[k] = 1; wc++;
          if (fkind != 0 && fidx == k) bad = 1;
        end
        k++;
      end
    end
    e_code[k] = 5; e_chk[k] = 0; k++;
    e_code[k] = 6; e_chk[k] = 0; k++;
    ecnt = k; eerr = bad;
  endtask

  task automatic prep();
    @(posedge clk); lclr = 1'b1;
    @(negedge clk); dclr = 1'b1;
    @(posedge clk); lclr = 1'b0;
    @(negedge clk); dclr = 1'b0;
    build_expected(wtaken);
  endtask

  task automatic launch();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic finish_and_check(input string req);
    int n = 0;
    bit got_done, got_err;
    while (!(done || err) && n < 3000) begin @(negedge clk); n++; end
    chk(n < 3000, req, "transaction finished", n, 0);
    got_done = done; got_err = err;
    chk(got_err == eerr[0] && got_done == !eerr[0], "R8",
        "result err flag", int'(got_err), eerr);
    @(negedge clk);
    chk(!done && !err, "R9", "finish pulse one cycle", int'(done | err), 0);
    repeat (8) @(negedge clk);
    chk(lcnt == ecnt, req, "command count", lcnt, ecnt);
    for (int i = 0; i < ecnt && i < lcnt; i++) begin
      chk(l_code[i] == e_code[i], req, $sformatf("cmd %0d code", i), l_code[i], e_code[i]);
      if (e_chk[i] != 0)
        chk(l_data[i] == e_data[i], req, $sformatf("cmd %0d data", i), l_data[i], e_data[i]);
    end
    chk(rcnt == erc, req, "read byte count", rcnt, erc);
    for (int i = 0; i < erc && i < rcnt; i++)
      chk(rbuf[i] == e_rd[i], req, $sformatf("read byte %0d", i), rbuf[i], e_rd[i]);
  endtask

  // {addr, rd, len, fault index, fault kind(0 none,1 nack,2 arb)}
  localparam logic [18:0] VEC [9] = '{
    {7'h50, 1'b0, 4'd2, 5'd0, 2'd0},
    {7'h21, 1'b1, 4'd3, 5'd0, 2'd0},
    {7'h11, 1'b0, 4'd0, 5'd0, 2'd0},
    {7'h40, 1'b0, 4'd3, 5'd2, 2'd1},
    {7'h33, 1'b0, 4'd1, 5'd0, 2'd1},
    {7'h62, 1'b1, 4'd2, 5'd1, 2'd2},
    {7'h0A, 1'b1, 4'd1, 5'd0, 2'd0},
    {7'h7F, 1'b1, 4'd0, 5'd0, 2'd0},
    {7'h05, 1'b0, 4'd2, 5'd0, 2'd2}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state (R9)
    chk(!done && !err, "R9", "done/err low in reset", int'(done | err), 0);
    chk(!cmd_valid && !desc_ready && !wr_ready && !rd_valid, "R9",
        "handshake outputs low in reset",
        int'({cmd_valid, desc_ready, wr_ready, rd_valid}), 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!cmd_valid && !desc_ready, "R9", "quiet after reset",
        int'({cmd_valid, desc_ready}), 0);

    // Single-message vectors (R2 R3 R4 R5 R10)
    foreach (VEC[i]) begin
      string tag;
      dn = 1;
      m_addr[0] = int'(VEC[i][18:12]); m_rd[0] = int'(VEC[i][11]);
      m_len[0]  = int'(VEC[i][10:7]);  m_ns[0] = 0;
      fidx = int'(VEC[i][6:2]); fkind = int'(VEC[i][1:0]);
      if (fkind == 0) fidx = 99;
      tag = (fkind == 1) ? "R4" : (fkind == 2) ? "R3" :
            (m_len[0] == 0) ? "R10" : (m_rd[0] != 0) ? "R5" : "R2";
      prep(); launch(); finish_and_check(tag);
    end

    // Repeated START and no-start chaining; first no-start ignored (R7, R1)
    dn = 3; fkind = 0; fidx = 99;
    m_addr[0] = 7'h2C; m_rd[0] = 0; m_len[0] = 2; m_ns[0] = 1;
    m_addr[1] = 7'h2C; m_rd[1] = 0; m_len[1] = 1; m_ns[1] = 1;
    m_addr[2] = 7'h2D; m_rd[2] = 1; m_len[2] = 2; m_ns[2] = 0;
    prep(); launch(); finish_and_check("R7");
    chk(l_code[0] == 1, "R1", "first message starts despite no-start flag", l_code[0], 1);

    // Write then read continued without START (R7)
    dn = 2;
    m_addr[0] = 7'h19; m_rd[0] = 0; m_len[0] = 1; m_ns[0] = 0;
    m_addr[1] = 7'h19; m_rd[1] = 1; m_len[1] = 2; m_ns[1] = 1;
    prep(); launch(); finish_and_check("R7");

    // Read stream stalled (R6)
    dn = 1;
    m_addr[0] = 7'h21; m_rd[0] = 1; m_len[0] = 3; m_ns[0] = 0;
    rd_ready = 1'b0;
    prep(); launch();
    repeat (40) @(negedge clk);
    chk(lcnt == 2, "R6", "no read issued while byte pending", lcnt, 2);
    chk(rd_valid && rd_data == 8'hA1, "R6", "pending byte held",
        int'(rd_data), 8'hA1);
    repeat (10) @(negedge clk);
    chk(rd_valid && rd_data == 8'hA1 && lcnt == 2, "R6", "still held after stall",
        int'(rd_data), 8'hA1);
    rd_ready = 1'b1;
    finish_and_check("R6");

    // go during a transaction is ignored (R11)
    dn = 1;
    m_addr[0] = 7'h44; m_rd[0] = 0; m_len[0] = 2; m_ns[0] = 0;
    prep(); launch();
    repeat (5) @(negedge clk);
    go = 1'b1; @(negedge clk); go = 1'b0;
    finish_and_check("R11");
    begin
      int extra = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (done || err || desc_ready) extra++;
      end
      chk(extra == 0, "R11", "no second transaction", extra, 0);
      chk(lcnt == ecnt, "R11", "no commands after finish", lcnt, ecnt);
      chk(dptr == 1, "R11", "descriptors taken", dptr, 1);
    end

    summary();
    $finish;
  end
endmodule